// File: doc/BRIEF.md
# Multi-Source Interrupt Event Monitor

This block collects a parameterised number of single-bit, clock-synchronous event inputs and folds them into one interrupt request line. Each source has a trigger mode fixed at elaboration time: level, rising edge or falling edge. For each source the block makes a registered trigger strobe. It also keeps one pending bit per source. An enable mask decides which pending bits can raise the interrupt. A write-one-to-clear strobe vector acknowledges edge events.

Source `k` always occupies bit `k` of every vector. A level source's pending bit tracks its input. It cannot be acknowledged, so the interrupt clears only when the input goes low. An edge source latches its event until software clears it. No data moves through the block, so every port is a plain control or status pin with no handshake.

Top module: `event_monitor`

## Requirements
- R1: While `rst_n` is low, `pending`, `trig_strobe` and `irq` are 0. The edge-history registers reset to 0, so an input held high through reset never gives a falling-edge strobe.
- R2: A level-mode source (mode code 0) has `trig_strobe[k]` equal to its input as sampled at the previous clock edge.
- R3: A rise-mode source (mode code 1) pulses `trig_strobe[k]` for exactly one cycle. The pulse comes one clock after its input goes from 0 to 1.
- R4: A fall-mode source (mode code 2) pulses `trig_strobe[k]` for exactly one cycle. The pulse comes one clock after its input goes from 1 to 0.
- R5: A trigger strobe sets the matching pending bit one clock later, whatever the state of `enable`.
- R6: A level-mode pending bit equals that source's strobe delayed by one clock. Writing its `clear_w1c` bit has no effect on it.
- R7: An edge-mode pending bit stays set until a cycle in which its `clear_w1c` bit is 1. It is then 0 from the next clock. A 0 in `clear_w1c` has no effect.
- R8: If an edge strobe and a clear for the same bit occur in the same cycle, the pending bit stays set.
- R9: `irq` is the OR over all sources of `pending[k] & enable[k]`, with no added delay. It is low when no pending bit is enabled.
- R10: Modes come from parameter `TRIG_MODES`, which holds two bits per source in bits `[2k+1:2k]` for source `k`. Code 3 acts as level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | N_SRC | Synchronous event inputs, bit k = source k |
| enable | input | N_SRC | Interrupt enable mask |
| clear_w1c | input | N_SRC | Per-bit clear strobe, sampled every cycle |
| trig_strobe | output | N_SRC | Registered trigger strobe per source |
| pending | output | N_SRC | Pending event vector |
| irq | output | 1 | Interrupt request |

## Verification
An edge strobe and a write-one-to-clear can land on the same pending bit in one clock. The bench provokes this by giving a rise source a fresh 0-to-1 input and then raising its clear bit in the very cycle the strobe is high. The expected result is a pending bit that is still set after that edge. A later clear on its own must then drop it. A clear aimed at a level source while its input is high is also checked, and it must leave the bit set.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_RISE  = 2'd1,
    TRIG_FALL  = 2'd2
  } trig_mode_e;
endpackage

// File: rtl/evmon_detect.sv
module evmon_detect #(
  parameter logic [1:0] MODE = evmon_pkg::TRIG_LEVEL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  output logic strobe_o
);
  import evmon_pkg::*;

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  generate
    if (MODE == TRIG_RISE || MODE == TRIG_FALL) begin : g_edge
      logic prev_q;
      logic hit;
      if (MODE == TRIG_RISE) begin : g_rise
        assign hit = ev_i & ~prev_q;
      end else begin : g_fall
        assign hit = ~ev_i & prev_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q   <= 1'b0;
          strobe_o <= 1'b0;
        end else begin
          prev_q   <= ev_i;
          strobe_o <= hit;
        end
      end

      // R3 / R4: edge strobes last one cycle
      p_edge_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);
      if (MODE == TRIG_FALL) begin : g_fall_chk
        p_fall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
          (seen_q && $rose(strobe_o)) |-> ($past(prev_q) && !$past(ev_i)));
      end
    end else begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_o <= 1'b0;
        else        strobe_o <= ev_i;
      end

      p_level_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (strobe_o == $past(ev_i)));
    end
  endgenerate
endmodule

// File: rtl/evmon_pend_bit.sv
module evmon_pend_bit #(
  parameter logic [1:0] MODE = evmon_pkg::TRIG_LEVEL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic clear_i,
  output logic pend_o
);
  import evmon_pkg::*;

  localparam bit IS_EDGE = (MODE == TRIG_RISE) || (MODE == TRIG_FALL);

  logic pend_d;

  generate
    if (IS_EDGE) begin : g_sticky
      assign pend_d = strobe_i | (pend_o & ~clear_i);

      p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clear_i) |=> pend_o);
      p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !strobe_i) |=> !pend_o);
      p_strobe_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && clear_i) |=> pend_o);
    end else begin : g_follow
      assign pend_d = strobe_i;

      p_level_noclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && clear_i) |=> pend_o);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= pend_d;
  end

  p_strobe_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> pend_o);
endmodule

// File: rtl/event_monitor.sv
module event_monitor #(
  parameter int                   N_SRC      = 3,
  parameter logic [2*N_SRC-1:0]   TRIG_MODES = 6'b10_01_00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] ev_in,
  input  logic [N_SRC-1:0] enable,
  input  logic [N_SRC-1:0] clear_w1c,
  output logic [N_SRC-1:0] trig_strobe,
  output logic [N_SRC-1:0] pending,
  output logic             irq
);
  import evmon_pkg::*;

  localparam int MW = MODE_W;

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    localparam logic [MW-1:0] M = TRIG_MODES[MW*k +: MW];

    evmon_detect #(.MODE(M)) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_i     (ev_in[k]),
      .strobe_o (trig_strobe[k])
    );

    evmon_pend_bit #(.MODE(M)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (trig_strobe[k]),
      .clear_i  (clear_w1c[k]),
      .pend_o   (pending[k])
    );
  end

  assign irq = |(pending & enable);

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);
  p_irq_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> !irq);
  always_comb begin
    if (!rst_n) p_reset_quiet_r1: assert (pending == '0 && trig_strobe == '0);
  end
endmodule

// File: tb/event_monitor_tb.sv
module event_monitor_tb;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] ev_in = '0, enable = '0, clear_w1c = '0;
  logic [N-1:0] trig_strobe, pending;
  logic irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  event_monitor #(.N_SRC(N), .TRIG_MODES(6'b10_01_00)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .enable(enable),
    .clear_w1c(clear_w1c), .trig_strobe(trig_strobe), .pending(pending), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  // Source 0 level, source 1 rise, source 2 fall (R10 bit order)
  task automatic t_reset();
    ev_in = 3'b101;
    tick(); tick();
    chk("R1 pending in reset", pending, 0);
    chk("R1 strobe in reset", trig_strobe, 0);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    tick();
    chk("R2/R10 level strobe, R1 no false fall", trig_strobe, 3'b001);
    tick();
    chk("R5 level pending set while masked", pending, 3'b001);
    chk("R9 irq masked", irq, 0);
  endtask

  task automatic t_level();
    enable = 3'b111; #1;
    chk("R9 irq on enable", irq, 1);
    clear_w1c = 3'b001; tick(); clear_w1c = '0;
    chk("R6 level ignores clear", pending, 3'b001);
    chk("R9 irq still high", irq, 1);
  endtask

  task automatic t_fall();
    ev_in = 3'b000; tick();
    chk("R4 fall strobe", trig_strobe, 3'b100);
    tick();
    chk("R4 fall strobe one cycle", trig_strobe, 3'b000);
    chk("R6 level drops, R5 fall pending", pending, 3'b100);
    tick();
    chk("R7 edge pending holds", pending, 3'b100);
    clear_w1c = 3'b010; tick(); clear_w1c = '0;
    chk("R7 zero clear no effect", pending, 3'b100);
    clear_w1c = 3'b100; tick(); clear_w1c = '0;
    chk("R7 clear drops edge bit", pending, 3'b000);
    chk("R9 irq low when none pending", irq, 0);
  endtask

  task automatic t_rise();
    ev_in = 3'b010; tick();
    chk("R3 rise strobe", trig_strobe, 3'b010);
    tick();
    chk("R3 rise strobe one cycle", trig_strobe, 3'b000);
    chk("R5 rise pending", pending, 3'b010);
    enable = 3'b101; #1;
    chk("R9 pending not enabled", irq, 0);
    enable = 3'b111; #1;
    chk("R9 pending enabled", irq, 1);
    clear_w1c = 3'b010; tick(); clear_w1c = '0;
    chk("R7 rise cleared", pending, 3'b000);
  endtask

  task automatic t_collide();
    ev_in = 3'b000; tick(); tick();
    ev_in = 3'b010; tick();
    chk("R3 second rise strobe", trig_strobe, 3'b010);
    clear_w1c = 3'b010; tick(); clear_w1c = '0;
    chk("R8 edge wins over clear", pending, 3'b010);
    clear_w1c = 3'b010; tick(); clear_w1c = '0;
    chk("R8 later clear drops bit", pending, 3'b000);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_level();
        t_fall();
        t_rise();
        t_collide();
      end
      begin
        repeat (2000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule